// File: doc/BRIEF.md
# Conversion Status Flag Register

This block is the status word of a converter sequencer, reached over a simple register bus. It keeps five sticky event flags:

- a regular-sequence start flag;
- an injected-group start flag;
- an injected-group completion flag;
- a conversion-complete flag;
- a threshold-window alarm.

Single-cycle pulses from the sequencer and from the window comparator set the flags. Each flag then holds until software removes it.

Software clears a flag by writing a 0 to its bit position. Writing a 1 leaves the bit as it is, so one write can clear any chosen subset without a read-modify-write race. The conversion-complete flag has a second way to clear: a strobe that marks a read of the conversion data register clears it, so a plain data fetch acknowledges the result. When a hardware set and a clear of the same flag land in the same cycle, the set takes priority, so no event is lost.

Top module: `conv_status_reg`

## Requirements
- R1: While `rst` is high and after it falls, all five flags are 0 and `bus_rdata` is 0.
- R2: Each flag sits at a fixed bit position and is set by its own event. Bit 4 is set by `ev_reg_start`. Bit 3 is set by `ev_inj_start`. Bit 0 is set by `ev_window`. A pulse in cycle t shows the flag as 1 on `flags_o` after that cycle's clock edge.
- R3: A set flag stays 1 for as long as no clear reaches it.
- R4: A bus write at offset 0x0 clears every flag whose bit in `bus_wdata` is 0. Flags whose write bit is 1 keep their value, and bits 31:5 of the write data have no effect.
- R5: A write to any offset other than 0x0 changes no flag.
- R6: Bit 1 (conversion complete) is set by `ev_reg_end`. It is also set by `ev_inj_end` when `inj_last` is 1.
- R7: Bit 2 (injected group complete) is set only by `ev_inj_end` together with `inj_last`=1. An `ev_inj_end` with `inj_last`=0 sets no flag.
- R8: A `dr_read` pulse clears bit 1 and leaves the other four flags unchanged.
- R9: A set event and a write-zero clear of the same flag in the same cycle leave the flag at 1.
- R10: A conversion-complete event and a `dr_read` pulse in the same cycle leave bit 1 at 1.
- R11: `bus_rd` at offset 0x0 in cycle t makes `bus_rdata` equal {27'b0, flags} one cycle later, using the flags as they were before the edge. A read at any other offset returns 0. Bits 31:5 always read 0, and a read never changes a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| ev_reg_start | input | 1 | Regular sequence started |
| ev_inj_start | input | 1 | Injected group started |
| ev_reg_end | input | 1 | Regular conversion finished |
| ev_inj_end | input | 1 | Injected channel finished |
| inj_last | input | 1 | Qualifies `ev_inj_end` as the last channel of the group |
| ev_window | input | 1 | Converted value left the threshold window |
| dr_read | input | 1 | Data register was read |
| flags_o | output | 5 | Current flag values |

## Verification
The bench targets the same-cycle collisions. If a design let the clear win, a write of zero or a data-register read coinciding with a set would leave the flag at 0. It also drives an injected channel finishing without the last-channel qualifier. A design that got this wrong would raise the group-complete flag too early.

Writes that mix ones and zeros and writes to a foreign offset are also checked. A design treating writes as plain stores would set bits or disturb unrelated flags. Reads are checked for stale or shifted data and for any side effect on the flags.

// File: rtl/conv_status_pkg.sv
package conv_status_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int BUS_DW    = 32;

  // Bit positions of the status flags; software decodes these.
  localparam int IDX_WINDOW    = 0;
  localparam int IDX_CONV_DONE = 1;
  localparam int IDX_GRP_DONE  = 2;
  localparam int IDX_INJ_START = 3;
  localparam int IDX_REG_START = 4;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/csr_bus_decode.sv
module csr_bus_decode #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NFLAG  = 5,
  parameter logic [ADDR_W-1:0] OFFSET = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_hit,
  output logic [NFLAG-1:0]  clr_mask
);
  logic sel;
  logic unused_hi;

  assign sel       = (addr == OFFSET);
  assign rd_hit    = rd & sel;
  // Zero written to a flag bit requests its clear; reserved bits are dropped.
  assign clr_mask  = (wr & sel) ? ~wdata[NFLAG-1:0] : '0;
  assign unused_hi = ^wdata[DATA_W-1:NFLAG];
endmodule

// File: rtl/csr_flag_bit.sv
module csr_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R9 / R10: a set in the same cycle as a clear leaves the flag at 1
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R4 / R8: a clear with no set drops the flag
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  // R3: with no set and no clear the flag holds its value
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/conv_status_reg.sv
module conv_status_reg
  import conv_status_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_OFFSET = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [BUS_DW-1:0]    bus_wdata,
  input  logic                 bus_rd,
  output logic [BUS_DW-1:0]    bus_rdata,
  input  logic                 ev_reg_start,
  input  logic                 ev_inj_start,
  input  logic                 ev_reg_end,
  input  logic                 ev_inj_end,
  input  logic                 inj_last,
  input  logic                 ev_window,
  input  logic                 dr_read,
  output logic [NUM_FLAGS-1:0] flags_o
);
  flag_vec_t set_vec, clr_vec, sw_clr, flags;
  logic      rd_hit;
  logic      grp_end;

  csr_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(BUS_DW), .NFLAG(NUM_FLAGS), .OFFSET(REG_OFFSET)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
    .rd_hit(rd_hit), .clr_mask(sw_clr)
  );

  assign grp_end = ev_inj_end & inj_last;

  always_comb begin
    set_vec                = '0;
    set_vec[IDX_WINDOW]    = ev_window;
    set_vec[IDX_CONV_DONE] = ev_reg_end | grp_end;
    set_vec[IDX_GRP_DONE]  = grp_end;
    set_vec[IDX_INJ_START] = ev_inj_start;
    set_vec[IDX_REG_START] = ev_reg_start;
    clr_vec                = sw_clr;
    clr_vec[IDX_CONV_DONE] = sw_clr[IDX_CONV_DONE] | dr_read;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    csr_flag_bit u_bit (
      .clk(clk), .rst(rst), .set_i(set_vec[g]), .clr_i(clr_vec[g]), .q_o(flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= {{(BUS_DW-NUM_FLAGS){1'b0}}, flags};
    else             bus_rdata <= '0;
  end

  assign flags_o = flags;

  // R11: reserved bits read zero
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_DW-1:NUM_FLAGS] == '0);
  // R11: a hit read returns the pre-edge flags
  a_r11_read_data: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_OFFSET) |=> bus_rdata[NUM_FLAGS-1:0] == $past(flags_o));
  // R5: a foreign write with no other activity changes nothing
  a_r5_foreign_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != REG_OFFSET && !ev_reg_start && !ev_inj_start &&
     !ev_reg_end && !ev_inj_end && !ev_window && !dr_read) |=> $stable(flags_o));
  // R7: a non-final injected channel alone leaves group-complete untouched
  a_r7_grp_needs_last: assert property (@(posedge clk) disable iff (rst)
    (!(ev_inj_end && inj_last) && !flags_o[IDX_GRP_DONE]) |=> !flags_o[IDX_GRP_DONE]);
  // R8: data-register read with no completion event clears bit 1
  a_r8_dr_read_clears: assert property (@(posedge clk) disable iff (rst)
    (dr_read && !ev_reg_end && !(ev_inj_end && inj_last)) |=> !flags_o[IDX_CONV_DONE]);
endmodule

// File: tb/conv_status_reg_bench.sv
module conv_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_reg_start = 0, ev_inj_start = 0, ev_reg_end = 0, ev_inj_end = 0;
  logic        inj_last = 0, ev_window = 0, dr_read = 0;
  logic [4:0]  flags_o;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  conv_status_reg u_conv_status_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ev_reg_start(ev_reg_start),
    .ev_inj_start(ev_inj_start), .ev_reg_end(ev_reg_end), .ev_inj_end(ev_inj_end),
    .inj_last(inj_last), .ev_window(ev_window), .dr_read(dr_read), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    ev_reg_start = 0; ev_inj_start = 0; ev_reg_end = 0; ev_inj_end = 0;
    inj_last = 0; ev_window = 0; dr_read = 0;
  endtask

  // Apply currently driven inputs for one cycle, then release and settle.
  task automatic step();
    @(posedge clk); #1;
    idle_all();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle_all();
    @(posedge clk); @(negedge clk); rst = 0;
    #1;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1; step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flags", {27'b0, flags_o}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
  endtask

  task automatic t_set_map();
    do_reset();
    @(negedge clk); ev_reg_start = 1; step();
    chk("R2 reg_start bit4", {27'b0, flags_o}, 32'h10);
    @(negedge clk); ev_inj_start = 1; step();
    chk("R2 inj_start bit3", {27'b0, flags_o}, 32'h18);
    @(negedge clk); ev_window = 1; step();
    chk("R2 window bit0", {27'b0, flags_o}, 32'h19);
    repeat (5) @(negedge clk);
    chk("R3 sticky", {27'b0, flags_o}, 32'h19);
  endtask

  task automatic t_conv_sources();
    do_reset();
    @(negedge clk); ev_reg_end = 1; step();
    chk("R6 reg_end sets bit1", {27'b0, flags_o}, 32'h02);
    do_reset();
    @(negedge clk); ev_inj_end = 1; inj_last = 0; step();
    chk("R7 non-last inj sets nothing", {27'b0, flags_o}, 32'h00);
    @(negedge clk); ev_inj_end = 1; inj_last = 1; step();
    chk("R7 R6 last inj sets bits 2,1", {27'b0, flags_o}, 32'h06);
  endtask

  task automatic t_sw_clear();
    do_reset();
    @(negedge clk); ev_reg_start = 1; ev_inj_start = 1; ev_window = 1; ev_reg_end = 1; step();
    @(negedge clk); ev_inj_end = 1; inj_last = 1; step();
    chk("R2 all set", {27'b0, flags_o}, 32'h1F);
    wr_reg(4'h0, 32'hFFFF_FFF5);  // zeros at bits 3 and 1
    chk("R4 write zero clears selected", {27'b0, flags_o}, 32'h15);
    wr_reg(4'h4, 32'h0);
    chk("R5 foreign write ignored", {27'b0, flags_o}, 32'h15);
    wr_reg(4'h0, 32'h0000_001F);
    chk("R4 write ones keeps", {27'b0, flags_o}, 32'h15);
    wr_reg(4'h0, 32'hFFFF_FFE0);
    chk("R4 reserved ones no effect", {27'b0, flags_o}, 32'h00);
  endtask

  task automatic t_dr_read();
    do_reset();
    @(negedge clk); ev_reg_end = 1; ev_window = 1; ev_reg_start = 1; step();
    @(negedge clk); dr_read = 1; step();
    chk("R8 dr_read clears only bit1", {27'b0, flags_o}, 32'h11);
    @(negedge clk); ev_reg_end = 1; dr_read = 1; step();
    chk("R10 set beats dr_read", {27'b0, flags_o}, 32'h13);
  endtask

  task automatic t_collide();
    do_reset();
    @(negedge clk); ev_window = 1; bus_addr = 4'h0; bus_wdata = 32'h0; bus_wr = 1; step();
    chk("R9 set beats write clear", {27'b0, flags_o}, 32'h01);
  endtask

  task automatic t_read();
    do_reset();
    @(negedge clk); ev_inj_start = 1; ev_window = 1; step();
    @(negedge clk); bus_addr = 4'h0; bus_rd = 1; ev_reg_start = 1; step();
    chk("R11 read returns pre-edge flags", bus_rdata, 32'h0000_0009);
    chk("R11 read no side effect", {27'b0, flags_o}, 32'h19);
    @(negedge clk); bus_addr = 4'h0; bus_rd = 1; step();
    chk("R11 second read", bus_rdata, 32'h0000_0019);
    @(negedge clk); bus_addr = 4'h8; bus_rd = 1; step();
    chk("R11 foreign read zero", bus_rdata, 32'h0);
    chk("R11 flags kept", {27'b0, flags_o}, 32'h19);
  endtask

  initial begin
    t_reset();
    t_set_map();
    t_conv_sources();
    t_sw_clear();
    t_dr_read();
    t_collide();
    t_read();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule